// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a small two-port mailbox between a host bus agent and a management controller. Each direction carries one byte at a time. The host deposits a byte into the inbound register. The controller deposits a byte into the outbound register. A shared eight-bit status register shows, through hardware flags, which of the two registers holds a byte the other side has not yet consumed. Each side gets a level interrupt that stays asserted while a byte waits for it.

Both sides use single-cycle synchronous strobes: a write strobe, a read strobe, a one-bit register select and a byte of write data. Read data is combinational from the selected register, so it is sampled in the same cycle as the read strobe. Any side effect of the read, such as clearing a flag, takes effect at the next clock edge.

The host has two ways to write the inbound register. With select 0 it writes a data byte; with select 1 it writes a command byte. A status bit records which kind arrived last. The spare status bits belong to controller firmware, which uses them as a software channel toward the host.

Each byte direction is a two-state machine:
- `CH_EMPTY` moves to `CH_FULL` on a producer write (LOAD).
- `CH_FULL` stays in `CH_FULL` on a producer write (REFILL, which overwrites the byte).
- `CH_FULL` moves to `CH_EMPTY` on a consumer read with no producer write in the same cycle (DRAIN).
- Otherwise each state holds (IDLE).

The command/data tracker is a two-state machine:
- `CD_DATA` moves to `CD_CMD` on a host write with select 1.
- `CD_CMD` moves to `CD_DATA` on a host write with select 0.
- Otherwise the state holds.

Top module: `hostctl_mailbox`

## Requirements
- R1: After reset, both data registers read 0x00, the status register reads 0x00 from both sides, and both interrupt outputs are low.
- R2: A host write with select 0 stores the byte in the inbound register. After the edge, status bit 1 (inbound full) is 1 and status bit 3 (command/data) is 0.
- R3: A host write with select 1 stores the byte in the inbound register. After the edge, status bit 1 is 1 and status bit 3 is 1.
- R4: A controller read with select 0 returns the inbound byte in the same cycle. Unless the host writes in that cycle, status bit 1 is 0 after the edge.
- R5: A controller write with select 0 stores the byte in the outbound register. After the edge, status bit 0 (outbound full) is 1.
- R6: A host read with select 0 returns the outbound byte in the same cycle. Unless the controller writes the outbound register in that cycle, status bit 0 is 0 after the edge.
- R7: A controller write with select 1 loads status bits 7:4 and 2 from the write data. Bits 0, 1 and 3 ignore it.
- R8: A host read with select 1 returns the status register. Host writes never change status bits 7:4 and 2.
- R9: The controller interrupt `irq_mc_o` equals status bit 1 and the host interrupt `irq_host_o` equals status bit 0, as levels in every cycle.
- R10: When a producer writes in the same cycle that the consumer reads the same register, the read returns the old byte, the new byte is stored, and the full flag stays 1.
- R11: Reads with select 1 from either side leave both full flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_sel_i | input | 1 | Host register select: 0 data, 1 command write / status read |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte: outbound register or status |
| mc_wr_i | input | 1 | Controller write strobe |
| mc_rd_i | input | 1 | Controller read strobe |
| mc_sel_i | input | 1 | Controller register select: 0 data, 1 status |
| mc_wdata_i | input | 8 | Controller write byte |
| mc_rdata_o | output | 8 | Controller read byte: inbound register or status |
| irq_mc_o | output | 1 | Level interrupt to the controller: inbound byte waiting |
| irq_host_o | output | 1 | Level interrupt to the host: outbound byte waiting |

## Verification
The bench checks cycles where a producer write and a consumer read of the same register collide. A design that lets the read win would drop the flag and lose a byte; one that forwards the new byte would return data the reader never saw announced. It writes all-ones into the status register from the controller side. A design without the protection mask would set the full flags or the command bit by software and raise a false interrupt. It also checks that status reads and host command writes leave the flags and spare bits alone, and that the command/data bit follows the last host write kind across long random runs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MB_W       = 8;
    localparam int OBF_POS    = 0;
    localparam int IBF_POS    = 1;
    localparam int CD_POS     = 3;
    localparam logic [MB_W-1:0] SPARE_MASK = ~((MB_W'(1) << OBF_POS) |
                                               (MB_W'(1) << IBF_POS) |
                                               (MB_W'(1) << CD_POS));

    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_FULL  = 1'b1
    } chan_st_e;

    typedef enum logic {
        CD_DATA = 1'b0,
        CD_CMD  = 1'b1
    } cd_st_e;
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int W = MB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         put_i,
    input  logic [W-1:0] put_data_i,
    input  logic         take_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    chan_st_e     st_q, st_d;
    logic [W-1:0] data_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_EMPTY;
        else        st_q <= st_d;
    end

    // transitions: LOAD, REFILL, DRAIN, IDLE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_EMPTY: if (put_i) st_d = CH_FULL;
            CH_FULL: begin
                if (put_i)       st_d = CH_FULL;
                else if (take_i) st_d = CH_EMPTY;
            end
            default: st_d = CH_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     data_q <= '0;
        else if (put_i) data_q <= put_data_i;
    end

    // outputs
    always_comb begin
        data_o = data_q;
        full_o = (st_q == CH_FULL);
    end
endmodule

// File: rtl/mbox_status.sv
module mbox_status
    import mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_we_i,
    input  logic [MB_W-1:0] sw_wdata_i,
    input  logic            host_we_i,
    input  logic            host_cmd_i,
    input  logic            ibf_i,
    input  logic            obf_i,
    output logic [MB_W-1:0] status_o
);
    cd_st_e          cd_q, cd_d;
    logic [MB_W-1:0] spare_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cd_q <= CD_DATA;
        else        cd_q <= cd_d;
    end

    always_comb begin
        cd_d = cd_q;
        unique case (cd_q)
            CD_DATA: if (host_we_i && host_cmd_i)  cd_d = CD_CMD;
            CD_CMD:  if (host_we_i && !host_cmd_i) cd_d = CD_DATA;
            default: cd_d = CD_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       spare_q <= '0;
        else if (sw_we_i) spare_q <= sw_wdata_i & SPARE_MASK;
    end

    always_comb begin
        status_o          = spare_q & SPARE_MASK;
        status_o[OBF_POS] = obf_i;
        status_o[IBF_POS] = ibf_i;
        status_o[CD_POS]  = (cd_q == CD_CMD);
    end
endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
    import mbox_pkg::*;
(
    input  logic            sel_i,
    input  logic [MB_W-1:0] data_i,
    input  logic [MB_W-1:0] status_i,
    output logic [MB_W-1:0] rdata_o
);
    always_comb rdata_o = sel_i ? status_i : data_i;
endmodule

// File: rtl/hostctl_mailbox.sv
module hostctl_mailbox
    import mbox_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_i,
    input  logic            host_rd_i,
    input  logic            host_sel_i,
    input  logic [MB_W-1:0] host_wdata_i,
    output logic [MB_W-1:0] host_rdata_o,
    input  logic            mc_wr_i,
    input  logic            mc_rd_i,
    input  logic            mc_sel_i,
    input  logic [MB_W-1:0] mc_wdata_i,
    output logic [MB_W-1:0] mc_rdata_o,
    output logic            irq_mc_o,
    output logic            irq_host_o
);
    logic [MB_W-1:0] in_data, out_data, status_w;
    logic            ibf, obf;
    logic            in_put, in_take, out_put, out_take, sw_we;

    always_comb begin
        in_put   = host_wr_i;
        in_take  = mc_rd_i   && !mc_sel_i;
        out_put  = mc_wr_i   && !mc_sel_i;
        out_take = host_rd_i && !host_sel_i;
        sw_we    = mc_wr_i   &&  mc_sel_i;
    end

    mbox_chan #(.W(MB_W)) u_in (
        .clk(clk), .rst_n(rst_n), .put_i(in_put), .put_data_i(host_wdata_i),
        .take_i(in_take), .data_o(in_data), .full_o(ibf)
    );

    mbox_chan #(.W(MB_W)) u_out (
        .clk(clk), .rst_n(rst_n), .put_i(out_put), .put_data_i(mc_wdata_i),
        .take_i(out_take), .data_o(out_data), .full_o(obf)
    );

    mbox_status u_stat (
        .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we), .sw_wdata_i(mc_wdata_i),
        .host_we_i(host_wr_i), .host_cmd_i(host_sel_i), .ibf_i(ibf), .obf_i(obf),
        .status_o(status_w)
    );

    mbox_rdmux u_hmux (
        .sel_i(host_sel_i), .data_i(out_data), .status_i(status_w), .rdata_o(host_rdata_o)
    );

    mbox_rdmux u_mmux (
        .sel_i(mc_sel_i), .data_i(in_data), .status_i(status_w), .rdata_o(mc_rdata_o)
    );

    always_comb begin
        irq_mc_o   = ibf;
        irq_host_o = obf;
    end
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            host_wr_i,
    input logic            host_rd_i,
    input logic            host_sel_i,
    input logic            mc_wr_i,
    input logic            mc_rd_i,
    input logic            mc_sel_i,
    input logic            irq_mc_o,
    input logic            irq_host_o,
    input logic [MB_W-1:0] status
);
    assert_hwr_sets_ibf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_i |=> irq_mc_o);

    assert_cmd_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_sel_i) |=> status[CD_POS]);

    assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_rd_i && !mc_sel_i && !host_wr_i) |=> !irq_mc_o);

    assert_mwr_sets_obf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_wr_i && !mc_sel_i) |=> irq_host_o);

    assert_hrd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !host_sel_i && !(mc_wr_i && !mc_sel_i)) |=> !irq_host_o);

    assert_spare_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_wr_i && mc_sel_i) |=> $stable(status & SPARE_MASK));

    assert_irq_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mc_o == status[IBF_POS]) && (irq_host_o == status[OBF_POS]));

    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr_i && !mc_wr_i && !(mc_rd_i && !mc_sel_i) && !(host_rd_i && !host_sel_i))
        |=> ($stable(irq_mc_o) && $stable(irq_host_o)));
endmodule

bind hostctl_mailbox mbox_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_sel_i(host_sel_i),
    .mc_wr_i(mc_wr_i), .mc_rd_i(mc_rd_i), .mc_sel_i(mc_sel_i),
    .irq_mc_o(irq_mc_o), .irq_host_o(irq_host_o), .status(status_w)
);

// File: tb/sim_hostctl_mailbox.sv
`timescale 1ns/1ps
module sim_hostctl_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_i = 0, host_rd_i = 0, host_sel_i = 0;
    logic [7:0] host_wdata_i = 0;
    logic [7:0] host_rdata_o;
    logic       mc_wr_i = 0, mc_rd_i = 0, mc_sel_i = 0;
    logic [7:0] mc_wdata_i = 0;
    logic [7:0] mc_rdata_o;
    logic       irq_mc_o, irq_host_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_idr = 0, m_odr = 0, m_spare = 0;
    logic       m_ibf = 0, m_obf = 0, m_cd = 0;

    always #4 clk = ~clk;

    hostctl_mailbox u0 (.*);

    function automatic logic [7:0] exp_status();
        return (m_spare & 8'hF4) | {4'b0, m_cd, 1'b0, m_ibf, m_obf};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle: check irqs, drive, check reads, advance model
    task automatic step(bit hw, bit hr, bit hs, logic [7:0] hd,
                        bit cw, bit cr, bit cs, logic [7:0] cd, string tag);
        logic n_ibf, n_obf, n_cd;
        logic [7:0] n_idr, n_odr, n_spare;
        @(negedge clk);
        chk((tag == "") ? "R9" : tag, {6'b0, irq_mc_o, irq_host_o}, {6'b0, m_ibf, m_obf});
        host_wr_i = hw; host_rd_i = hr; host_sel_i = hs; host_wdata_i = hd;
        mc_wr_i = cw; mc_rd_i = cr; mc_sel_i = cs; mc_wdata_i = cd;
        #1;
        if (hr) chk((tag != "") ? tag : (hs ? "R8" : "R6"), host_rdata_o, hs ? exp_status() : m_odr);
        if (cr) chk((tag != "") ? tag : (cs ? "R7" : "R4"), mc_rdata_o,   cs ? exp_status() : m_idr);
        n_ibf   = hw ? 1'b1 : ((cr && !cs) ? 1'b0 : m_ibf);
        n_idr   = hw ? hd : m_idr;
        n_cd    = hw ? hs : m_cd;
        n_obf   = (cw && !cs) ? 1'b1 : ((hr && !hs) ? 1'b0 : m_obf);
        n_odr   = (cw && !cs) ? cd : m_odr;
        n_spare = (cw && cs) ? (cd & 8'hF4) : m_spare;
        @(posedge clk);
        m_ibf = n_ibf; m_idr = n_idr; m_cd = n_cd;
        m_obf = n_obf; m_odr = n_odr; m_spare = n_spare;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        step(0,1,1,0, 0,1,1,0, "R1");
        step(0,1,0,0, 0,1,0,0, "R1");
        // R2 data write then status check
        step(1,0,0,8'hA5, 0,0,0,0, "R2");
        step(0,0,0,0, 0,1,1,0, "R2");
        // R4 controller takes byte
        step(0,0,0,0, 0,1,0,0, "R4");
        step(0,1,1,0, 0,0,0,0, "R4");
        // R3 command write
        step(1,0,1,8'h3C, 0,0,0,0, "R3");
        step(0,1,1,0, 0,0,0,0, "R3");
        // R11 status reads keep flags
        step(0,1,1,0, 0,1,1,0, "R11");
        step(0,1,1,0, 0,1,1,0, "R11");
        // R10 collision on inbound: host writes while controller reads
        step(1,0,0,8'h77, 0,1,0,0, "R10");
        step(0,0,0,0, 0,1,0,0, "R10");
        // R5 / R6 outbound path
        step(0,0,0,0, 1,0,0,8'hC3, "R5");
        step(0,1,1,0, 0,0,0,0, "R5");
        step(0,1,0,0, 0,0,0,0, "R6");
        // R10 collision on outbound
        step(0,0,0,0, 1,0,0,8'h11, "R10");
        step(0,1,0,0, 1,0,0,8'h22, "R10");
        step(0,1,0,0, 0,0,0,0, "R10");
        // R7 controller writes all ones to status: flags and command bit protected
        step(0,0,0,0, 1,0,1,8'hFF, "R7");
        step(0,0,0,0, 0,1,1,0, "R7");
        step(0,1,1,0, 0,0,0,0, "R7");
        // R8 host command write leaves spare bits
        step(1,0,1,8'h00, 0,0,0,0, "R8");
        step(0,1,1,0, 0,0,0,0, "R8");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0,3) == 0, $urandom_range(0,2) == 0, $urandom_range(0,1),
                 8'($urandom), $urandom_range(0,3) == 0, $urandom_range(0,2) == 0,
                 $urandom_range(0,1), 8'($urandom), "");
        end
        step(0,0,0,0, 0,0,0,0, "R9");
        finish_run();
    end
endmodule